// File: doc/BRIEF.md
# GPIO Configuration Lock Controller

This block guards the configuration of one GPIO port. It holds a lock bit for each lockable pin, a key bit, and a mode register with two bits per pin. Software sets the lock bits it wants. It then activates the key by writing the lock register three times in a row, with the key bit at 1, then 0, then 1. The lock field must be the same in all three writes.

Once the key is active, the lock bits are frozen. Mode writes to the locked pins are dropped. This lasts until the block is reset. A wrong step or a changed lock field abandons the attempt, and the key stays inactive.

Software reaches both registers through a simple synchronous port with a write strobe, a read strobe, a one-bit register select and 32-bit data. The lock vector and the mode fields are also driven out continuously to the logic they protect.

Top module: `gpio_cfg_lock`

## Requirements
- R1: Reset (rst_ni low) clears the lock bits, the key, the sequence tracker, the mode register and rdata_o to zero.
- R2: A read with sel_i=0 returns the lock register, and a read with sel_i=1 returns the mode register. The lock register holds lock bits at positions 0-3 and 8-11 (bit n = pin n) and the key at bit 16; every other bit reads 0. rdata_o is loaded on the clock edge that samples re_i=1 and holds its value otherwise.
- R3: While the key is 0, every write with sel_i=0 loads wdata_i[15:0], masked to the lockable positions, into the lock bits. This takes effect on lock_o at the next edge, whatever the value of bit 16.
- R4: The key sets only after three consecutive lock-register writes with bit 16 = 1, 0, 1 and an identical lock field. key_o goes high at the edge that samples the third write.
- R5: If the lock field in step two or step three differs from the field of step one, the attempt is abandoned and key_o stays 0.
- R6: A step with the wrong bit-16 value abandons the attempt. If that step has bit 16 = 1, it counts as a fresh first step, so the series 1,1,0,1 with an unchanged field sets the key.
- R7: Once the key is 1, it stays 1 until reset, and lock-register writes change neither the lock bits nor the key.
- R8: A write with sel_i=1 loads wdata_i[2p+1:2p] into the mode field of each pin p, except a pin whose lock bit is set while the key is 1. Such a pin keeps its old field. Pins 4-7 and 12-15 are always writable.
- R9: Mode-register writes and all reads between the steps of a key series neither advance nor abandon it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| sel_i | input | 1 | Register select: 0 lock register, 1 mode register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| lock_o | output | 16 | Current lock bits per pin |
| key_o | output | 1 | Key active |
| mode_o | output | 32 | Mode fields, two bits per pin |

## Verification
Every result is due exactly one clock edge after its stimulus:
- read data after the edge that samples re_i,
- lock_o and mode_o after the write edge,
- key_o after the edge of the third correct write.

The bench drives on the falling edge, so each result is sampled at the next falling edge. The read scoreboard pops an expected word only when a read strobe was captured at the preceding rising edge. The key is checked both at the falling edge just before the third write and at the falling edge just after it, which pins down the cycle in which it rises.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
  localparam int unsigned NUM_PINS = 16;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned KEY_POS  = 16;
  localparam logic [NUM_PINS-1:0] LOCKABLE = 16'h0F0F;

  localparam logic SEL_LOCK = 1'b0;
  localparam logic SEL_MODE = 1'b1;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GOT1 = 2'd1,
    SEQ_GOT0 = 2'd2
  } seq_state_e;
endpackage

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
  import gpio_lock_pkg::*;
#(
  parameter int unsigned N_PINS = NUM_PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              key_bit_i,
  input  logic [N_PINS-1:0] field_i,
  input  logic              key_active_i,
  output logic              done_o
);
  seq_state_e        state_q, state_d;
  logic [N_PINS-1:0] cap_q, cap_d;

  always_comb begin
    state_d = state_q;
    cap_d   = cap_q;
    done_o  = 1'b0;
    if (wr_i && !key_active_i) begin
      unique case (state_q)
        SEQ_IDLE: if (key_bit_i) begin
          state_d = SEQ_GOT1;
          cap_d   = field_i;
        end
        SEQ_GOT1: begin
          if (!key_bit_i && field_i == cap_q) state_d = SEQ_GOT0;
          else if (key_bit_i) begin
            state_d = SEQ_GOT1;       // deviation, fresh first step
            cap_d   = field_i;
          end else state_d = SEQ_IDLE;
        end
        SEQ_GOT0: begin
          if (key_bit_i && field_i == cap_q) begin
            done_o  = 1'b1;
            state_d = SEQ_IDLE;
          end else if (key_bit_i) begin
            state_d = SEQ_GOT1;
            cap_d   = field_i;
          end else state_d = SEQ_IDLE;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cap_q   <= '0;
    end else begin
      state_q <= state_d;
      cap_q   <= cap_d;
    end
  end

  assert_got0_from_got1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_GOT0 && $past(state_q) != SEQ_GOT0) |-> $past(state_q) == SEQ_GOT1);

  assert_idle_when_keyed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_active_i |=> state_q == SEQ_IDLE);
endmodule

// File: rtl/lock_key_reg.sv
module lock_key_reg
  import gpio_lock_pkg::*;
#(
  parameter int unsigned        N_PINS = NUM_PINS,
  parameter logic [N_PINS-1:0]  LMASK  = LOCKABLE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [N_PINS-1:0] field_i,
  input  logic              done_i,
  output logic [N_PINS-1:0] lock_o,
  output logic              key_o
);
  logic [N_PINS-1:0] lock_q;
  logic              key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      key_q  <= 1'b0;
    end else begin
      if (wr_i && !key_q) lock_q <= field_i & LMASK;
      if (done_i)         key_q  <= 1'b1;
    end
  end

  assign lock_o = lock_q;
  assign key_o  = key_q;

  assert_key_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_q |=> key_q);

  assert_lock_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_q |=> $stable(lock_q));

  assert_key_from_seq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(key_q) |-> $past(done_i));
endmodule

// File: rtl/mode_reg.sv
module mode_reg
  import gpio_lock_pkg::*;
#(
  parameter int unsigned N_PINS = NUM_PINS,
  parameter int unsigned FW     = MODE_W,
  localparam int unsigned W     = N_PINS * FW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              key_i,
  input  logic [N_PINS-1:0] lock_i,
  output logic [W-1:0]      mode_o
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [FW-1:0] fld_q;
    logic          frozen;

    assign frozen = key_i & lock_i[p];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                fld_q <= '0;
      else if (wr_i && !frozen)   fld_q <= wdata_i[p*FW +: FW];
    end

    assign mode_o[p*FW +: FW] = fld_q;

    assert_mode_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && key_i && lock_i[p]) |=> $stable(mode_o[p*FW +: FW]));

    assert_mode_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !(key_i && lock_i[p])) |=> mode_o[p*FW +: FW] == $past(wdata_i[p*FW +: FW]));
  end
endmodule

// File: rtl/gpio_cfg_lock.sv
module gpio_cfg_lock
  import gpio_lock_pkg::*;
#(
  parameter int unsigned N_PINS = NUM_PINS,
  parameter int unsigned FW     = MODE_W,
  parameter int unsigned DW     = REG_W,
  parameter int unsigned KPOS   = KEY_POS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 re_i,
  input  logic                 sel_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic [N_PINS-1:0]    lock_o,
  output logic                 key_o,
  output logic [N_PINS*FW-1:0] mode_o
);
  logic              lock_wr, mode_wr, done;
  logic [N_PINS-1:0] field;
  logic [DW-1:0]     lock_view, rdata_q;

  assign lock_wr = we_i && (sel_i == SEL_LOCK);
  assign mode_wr = we_i && (sel_i == SEL_MODE);
  assign field   = wdata_i[N_PINS-1:0] & LOCKABLE;

  lock_seq_fsm #(.N_PINS(N_PINS)) u_seq (
    .clk_i, .rst_ni,
    .wr_i        (lock_wr),
    .key_bit_i   (wdata_i[KPOS]),
    .field_i     (field),
    .key_active_i(key_o),
    .done_o      (done)
  );

  lock_key_reg #(.N_PINS(N_PINS), .LMASK(LOCKABLE)) u_lock (
    .clk_i, .rst_ni,
    .wr_i   (lock_wr),
    .field_i(field),
    .done_i (done),
    .lock_o (lock_o),
    .key_o  (key_o)
  );

  mode_reg #(.N_PINS(N_PINS), .FW(FW)) u_mode (
    .clk_i, .rst_ni,
    .wr_i   (mode_wr),
    .wdata_i(wdata_i[N_PINS*FW-1:0]),
    .key_i  (key_o),
    .lock_i (lock_o),
    .mode_o (mode_o)
  );

  always_comb begin
    lock_view               = '0;
    lock_view[N_PINS-1:0]   = lock_o;
    lock_view[KPOS]         = key_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= (sel_i == SEL_MODE) ? DW'(mode_o) : lock_view;
  end

  assign rdata_o = rdata_q;

  assert_rdata_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  assert_lock_rd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && sel_i == SEL_LOCK) |=> rdata_o[KPOS] == $past(key_o));
endmodule

// File: tb/tb_gpio_cfg_lock.sv
module tb_gpio_cfg_lock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0, sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] lock;
  logic        key;
  logic [31:0] mode;

  int n_cmp = 0, n_bad = 0;
  bit done_flag = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;

  always #4 clk = ~clk;

  gpio_cfg_lock dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .sel_i(sel),
    .wdata_i(wdata), .rdata_o(rdata), .lock_o(lock), .key_o(key), .mode_o(mode)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: all tasks start and end at a falling edge
  task automatic wr(input logic s, input logic [31:0] d);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic s, input logic [31:0] exp, input string tag);
    re = 1'b1; sel = s;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    re = 1'b0;
  endtask

  // monitor
  always @(posedge clk) rd_pend <= re;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2: unexpected read data %h expected none", rdata);
      end else begin
        chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({16'b0, lock}, 32'h0, "R1 lock_o after reset");
    chk({31'b0, key}, 32'h0, "R1 key_o after reset");
    chk(mode, 32'h0, "R1 mode_o after reset");
    chk(rdata, 32'h0, "R1 rdata_o after reset");
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, 32'h0, "R1 lock reg read");
    rd(1'b1, 32'h0, "R1 mode reg read");

    // R2/R3 direct lock writes, unimplemented bits read zero
    wr(1'b0, 32'hFFFF_FFFF);
    chk({16'b0, lock}, 32'h0F0F, "R3 lock_o after all-ones write");
    rd(1'b0, 32'h0000_0F0F, "R2 lock layout");
    chk({31'b0, key}, 32'h0, "R3 key stays 0");
    wr(1'b0, 32'h0000_0005);
    rd(1'b0, 32'h0000_0005, "R3 lock rewrite");

    // R8 unlocked mode writes
    wr(1'b1, 32'h1234_5678);
    chk(mode, 32'h1234_5678, "R8 mode_o unlocked write");
    rd(1'b1, 32'h1234_5678, "R8 mode read unlocked");

    // R5 field mismatch in step three
    wr(1'b0, 32'h0001_0003);
    wr(1'b0, 32'h0000_0003);
    wr(1'b0, 32'h0001_0007);
    @(negedge clk);
    chk({31'b0, key}, 32'h0, "R5 mismatch step3");
    rd(1'b0, 32'h0000_0007, "R5 lock follows mask");
    wr(1'b0, 32'h0000_0000);
    // R5 mismatch in step two
    wr(1'b0, 32'h0001_0100);
    wr(1'b0, 32'h0000_0200);
    wr(1'b0, 32'h0001_0100);
    chk({31'b0, key}, 32'h0, "R5 mismatch step2");

    // R6 wrong order 1,0,0 aborts
    wr(1'b0, 32'h0001_0003);
    wr(1'b0, 32'h0000_0003);
    wr(1'b0, 32'h0000_0003);
    wr(1'b0, 32'h0001_0003);
    chk({31'b0, key}, 32'h0, "R6 order 1,0,0,1");

    // R6 1,1,0,1 succeeds; R9 mode write and read interleaved
    wr(1'b1, 32'hAAAA_AAAA);
    wr(1'b0, 32'h0001_0903);
    wr(1'b0, 32'h0001_0903);
    wr(1'b1, 32'hAAAA_AAAA);
    rd(1'b0, 32'h0000_0903, "R9 read mid sequence");
    wr(1'b0, 32'h0000_0903);
    rd(1'b1, 32'hAAAA_AAAA, "R9 mode read mid sequence");
    chk({31'b0, key}, 32'h0, "R4 key low before third write");
    wr(1'b0, 32'h0001_0903);
    chk({31'b0, key}, 32'h1, "R4 key high after third write");
    chk({16'b0, lock}, 32'h0903, "R4 lock_o");
    rd(1'b0, 32'h0001_0903, "R4 key bit reads 1");

    // R7 writes ignored once keyed
    wr(1'b0, 32'h0000_FFFF);
    wr(1'b0, 32'h0000_0000);
    chk({31'b0, key}, 32'h1, "R7 key sticky");
    rd(1'b0, 32'h0001_0903, "R7 lock frozen");

    // R8 locked pins keep their fields
    wr(1'b1, 32'hFFFF_FFFF);
    chk(mode, 32'hFFBE_FFFA, "R8 mode all ones");
    wr(1'b1, 32'h0000_0000);
    rd(1'b1, 32'h0082_000A, "R8 mode all zeros");

    repeat (2) @(negedge clk);
    chk(exp_q.size(), 32'h0, "R2 scoreboard drained");

    // R1 reset clears the sticky key
    rst_n = 1'b0;
    @(negedge clk);
    chk({31'b0, key}, 32'h0, "R1 key cleared by reset");
    chk({16'b0, lock}, 32'h0, "R1 lock cleared by reset");
    chk(mode, 32'h0, "R1 mode cleared by reset");
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule